// File: doc/BRIEF.md
# Write-Protect Command Sequence Guard

This block sits beside the write path of a byte-wide non-volatile memory and watches every write that the memory accepts. It recognises a fixed three-write key made of address/data pairs. The key ending in the arm code turns on a persistent write-protect flag and admits the page of writes that follows it. The key ending in the off code removes the flag. For each accepted write it drives exactly one verdict: commit the data, treat the byte as a command byte that is never stored, or run a dummy timed cycle that stores nothing.

The write sequencer reports the end of each internal timed write cycle with a one-cycle `cycle_done` pulse. Protection changes state only on that pulse, so a new key takes effect once its own write-cycle time has passed. The authorised window also closes on that pulse. The protect flag has no reset term. It starts cleared and keeps its value through any reset, which models a persistent bit. The key addresses and codes are parameters.

Top module: `wp_seq_guard`

## Requirements
- R1: After the first reset `protect_on` is 0. While `wr_valid` is 0, `commit_en`, `cmd_byte` and `dummy_cycle` are all 0.
- R2: With protection off, a write that is not part of a key raises `commit_en` in the same cycle.
- R3: The key is three accepted writes: data 0xAA at address 0x1555, then 0x55 at 0x0AAA, then either 0xA0 (arm) or 0x20 (off) at 0x1555. Each write that matches the expected step raises `cmd_byte` and never `commit_en`.
- R4: A write that does not match the expected step returns the matcher to the first step. That write is judged as data, so address 0x1555 stays usable for ordinary data.
- R5: Completing the arm key sets `protect_on` at the next `cycle_done` and not before.
- R6: While protection is on and no key has authorised the write, a write raises `dummy_cycle` and not `commit_en`.
- R7: After an arm key, every write up to and including the cycle of the next `cycle_done` is committed, even under protection. Writes after that pulse fall under R6 again.
- R8: Completing the off key clears `protect_on` at the next `cycle_done`. Writes before that pulse are still treated as protected.
- R9: Reset leaves `protect_on` unchanged. Reset clears the matcher step, the authorised window and any pending arm or off.
- R10: A write in the same cycle as `cycle_done` is judged with the state from before that edge. A key completed in the same cycle as `cycle_done` keeps its new authorised window.
- R11: Whenever `wr_valid` is 1, exactly one of `commit_en`, `cmd_byte` and `dummy_cycle` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; does not touch the protect flag |
| wr_valid | input | 1 | A write is accepted by the memory this cycle |
| wr_addr | input | AW (13) | Address of the accepted write |
| wr_data | input | DW (8) | Data of the accepted write |
| cycle_done | input | 1 | End of an internal timed write cycle, one-cycle pulse |
| commit_en | output | 1 | Store this write's data in the array |
| cmd_byte | output | 1 | This write is a key byte; do not store it |
| dummy_cycle | output | 1 | Run the timed cycle but store nothing |
| protect_on | output | 1 | Persistent write-protect flag |

## Verification
The end of a write cycle can fall in the same edge as either a data write inside the authorised window or the final byte of a new key. The bench drives `cycle_done` together with such a write. It expects the coinciding data byte to be committed under the old window and the following byte to be a dummy cycle. In the other case it expects a key finished on the pulse to keep its window, so the next byte commits and protection arrives only at the following pulse.

// File: rtl/wp_seq_guard.sv
module wp_seq_guard #(
  parameter int AW = 13,
  parameter int DW = 8,
  parameter logic [AW-1:0] KEY_ADDR_1 = 13'h1555,
  parameter logic [AW-1:0] KEY_ADDR_2 = 13'h0AAA,
  parameter logic [DW-1:0] KEY_DATA_1 = 8'hAA,
  parameter logic [DW-1:0] KEY_DATA_2 = 8'h55,
  parameter logic [DW-1:0] KEY_ARM    = 8'hA0,
  parameter logic [DW-1:0] KEY_OFF    = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          cycle_done,
  output logic          commit_en,
  output logic          cmd_byte,
  output logic          dummy_cycle,
  output logic          protect_on
);

  logic [1:0] step_q;
  logic       auth_q, arm_q, off_q;
  logic       prot_q = 1'b0;
  logic       step_hit, key_end, end_arm, end_off;

  always_comb begin
    case (step_q)
      2'd0:    step_hit = (wr_addr == KEY_ADDR_1) && (wr_data == KEY_DATA_1);
      2'd1:    step_hit = (wr_addr == KEY_ADDR_2) && (wr_data == KEY_DATA_2);
      default: step_hit = (wr_addr == KEY_ADDR_1) &&
                          ((wr_data == KEY_ARM) || (wr_data == KEY_OFF));
    endcase
  end

  assign cmd_byte    = wr_valid && !auth_q && step_hit;
  assign key_end     = cmd_byte && (step_q == 2'd2);
  assign end_arm     = key_end && (wr_data == KEY_ARM);
  assign end_off     = key_end && (wr_data == KEY_OFF);
  assign commit_en   = wr_valid && !cmd_byte && (!prot_q || auth_q);
  assign dummy_cycle = wr_valid && !cmd_byte && prot_q && !auth_q;
  assign protect_on  = prot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= 2'd0;
      auth_q <= 1'b0;
      arm_q  <= 1'b0;
      off_q  <= 1'b0;
    end else begin
      if (wr_valid && !auth_q)
        step_q <= (cmd_byte && !key_end) ? step_q + 2'd1 : 2'd0;
      if (end_arm)         auth_q <= 1'b1;
      else if (cycle_done) auth_q <= 1'b0;
      if (end_arm)         {arm_q, off_q} <= 2'b10;
      else if (end_off)    {arm_q, off_q} <= 2'b01;
      else if (cycle_done) {arm_q, off_q} <= 2'b00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && cycle_done) begin
      if (arm_q)      prot_q <= 1'b1;
      else if (off_q) prot_q <= 1'b0;
    end
  end

endmodule

module wp_seq_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic cycle_done,
  input logic commit_en,
  input logic cmd_byte,
  input logic dummy_cycle,
  input logic protect_on
);

  assert_one_role_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($countones({commit_en, cmd_byte, dummy_cycle}) == 1));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> !(commit_en || cmd_byte || dummy_cycle));

  assert_rise_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(protect_on) |-> $past(cycle_done));

  assert_fall_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(protect_on) |-> $past(cycle_done));

  assert_keep_in_reset_R9: assert property (@(posedge clk)
    !rst_n |=> $stable(protect_on));

  assert_window_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (protect_on && wr_valid && !cmd_byte && $past(cycle_done) && !$past(cmd_byte))
      |-> !commit_en);

endmodule

bind wp_seq_guard wp_seq_guard_chk chk_i (.*);

// File: tb/wp_seq_guard_tb_top.sv
module wp_seq_guard_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cycle_done = 1'b0;
  logic        commit_en, cmd_byte, dummy_cycle, protect_on;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  wp_seq_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .cycle_done(cycle_done), .commit_en(commit_en),
    .cmd_byte(cmd_byte), .dummy_cycle(dummy_cycle), .protect_on(protect_on)
  );

  // {valid, addr, data, done, exp commit/cmd/dummy/protect, requirement}
  localparam logic [30:0] VEC [NV] = '{
    {1'b1, 13'h0100, 8'h3C, 1'b0, 4'b1000, 4'd2},  // R2 plain write
    {1'b1, 13'h1555, 8'hAA, 1'b0, 4'b0100, 4'd3},  // R3 key step 1
    {1'b1, 13'h0AAA, 8'h55, 1'b0, 4'b0100, 4'd3},  // R3 key step 2
    {1'b1, 13'h1555, 8'hA0, 1'b0, 4'b0100, 4'd3},  // R3 arm byte
    {1'b1, 13'h0200, 8'h11, 1'b0, 4'b1000, 4'd5},  // R5 not yet protected
    {1'b0, 13'h0000, 8'h00, 1'b1, 4'b0000, 4'd5},  // R5 done pulse
    {1'b1, 13'h0300, 8'h22, 1'b0, 4'b0011, 4'd6},  // R6 dummy
    {1'b1, 13'h1555, 8'hAA, 1'b0, 4'b0101, 4'd3},
    {1'b1, 13'h0123, 8'h99, 1'b0, 4'b0011, 4'd4},  // R4 break
    {1'b1, 13'h0AAA, 8'h55, 1'b0, 4'b0011, 4'd4},  // R4 restarted at step 1
    {1'b1, 13'h1555, 8'hAA, 1'b0, 4'b0101, 4'd3},
    {1'b1, 13'h0AAA, 8'h55, 1'b0, 4'b0101, 4'd3},
    {1'b1, 13'h1555, 8'hA0, 1'b0, 4'b0101, 4'd3},
    {1'b1, 13'h1555, 8'h77, 1'b0, 4'b1001, 4'd7},  // R7 key address as data
    {1'b1, 13'h0400, 8'h44, 1'b1, 4'b1001, 4'd10}, // R10 write with done
    {1'b1, 13'h0401, 8'h45, 1'b0, 4'b0011, 4'd7},  // R7 window closed
    {1'b1, 13'h1555, 8'hAA, 1'b0, 4'b0101, 4'd3},
    {1'b1, 13'h0AAA, 8'h55, 1'b0, 4'b0101, 4'd3},
    {1'b1, 13'h1555, 8'h20, 1'b0, 4'b0101, 4'd3},  // R3 off byte
    {1'b1, 13'h0500, 8'h50, 1'b0, 4'b0011, 4'd8},  // R8 still protected
    {1'b0, 13'h0000, 8'h00, 1'b1, 4'b0001, 4'd8},
    {1'b1, 13'h0500, 8'h50, 1'b0, 4'b1000, 4'd8},  // R8 cleared
    {1'b1, 13'h1555, 8'hAA, 1'b0, 4'b0100, 4'd3},
    {1'b1, 13'h1555, 8'h12, 1'b0, 4'b1000, 4'd4},  // R4 break, committed
    {1'b1, 13'h1555, 8'hAA, 1'b0, 4'b0100, 4'd3},
    {1'b1, 13'h0AAA, 8'h55, 1'b0, 4'b0100, 4'd3},
    {1'b1, 13'h1555, 8'hA0, 1'b1, 4'b0100, 4'd10}, // R10 key ends on done
    {1'b1, 13'h0600, 8'h66, 1'b0, 4'b1000, 4'd10}, // R10 window kept
    {1'b0, 13'h0000, 8'h00, 1'b1, 4'b0000, 4'd5},
    {1'b1, 13'h0601, 8'h67, 1'b0, 4'b0011, 4'd5}   // R5 protected now
  };

  task automatic drive(input logic v, input logic [12:0] a, input logic [7:0] d,
                       input logic dn);
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; cycle_done = dn;
    #1;
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {commit_en, cmd_byte, dummy_cycle, protect_on};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: commit/cmd/dummy/prot actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 5000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1 reset state", 4'b0000);
    @(negedge clk) rst_n = 1'b1;
    #1 check("R1 idle after reset", 4'b0000);

    // R11 exclusivity is part of every exact vector compare
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][30], VEC[i][29:17], VEC[i][16:9], VEC[i][8]);
      check($sformatf("R%0d vec %0d", VEC[i][3:0], i), VEC[i][7:4]);
    end

    // R9: reset keeps protection
    drive(1'b0, '0, '0, 1'b0);
    rst_n = 1'b0;
    repeat (3) drive(1'b0, '0, '0, 1'b0);
    check("R9 protect kept in reset", 4'b0001);
    rst_n = 1'b1;

    // R9: reset clears matcher step
    drive(1'b1, 13'h1555, 8'hAA, 1'b0);
    check("R9 key step before reset", 4'b0101);
    drive(1'b0, '0, '0, 1'b0);
    rst_n = 1'b0;
    drive(1'b0, '0, '0, 1'b0);
    rst_n = 1'b1;
    drive(1'b1, 13'h0AAA, 8'h55, 1'b0);
    check("R9 matcher cleared", 4'b0011);

    // R9: reset clears authorised window
    drive(1'b1, 13'h1555, 8'hAA, 1'b0);
    drive(1'b1, 13'h0AAA, 8'h55, 1'b0);
    drive(1'b1, 13'h1555, 8'hA0, 1'b0);
    check("R9 arm byte", 4'b0101);
    drive(1'b0, '0, '0, 1'b0);
    rst_n = 1'b0;
    drive(1'b0, '0, '0, 1'b0);
    rst_n = 1'b1;
    drive(1'b1, 13'h0700, 8'h70, 1'b0);
    check("R9 window cleared", 4'b0011);
    drive(1'b0, '0, '0, 1'b0);
    check("R11 idle outputs", 4'b0001);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule